// File: doc/BRIEF.md
# Half-Cycle Video Bus Arbiter

This block lets an 8-bit CPU and a read-only text-video fetcher share one memory bus without halting the CPU. A fast system clock drives it, and it divides that clock to produce the CPU phase clock `phi2`. The bus is split by phase. While `phi2` is high the CPU owns the bus. During the low half of each cycle the block removes the CPU from the bus through its bus-enable line, holds the shared read/write line at the read level, and performs one video read.

Strobe timing comes from a tap register clocked by the fast clock. The register holds a delayed copy of `phi2`. The CPU-side memory strobe is allowed only when both `phi2` and the delayed copy are high. The video strobe is held off by the same number of taps after the falling edge. This gives address decode time to settle at each change of owner, so no spurious select reaches the memory.

Video fetch requests come from an external queue as an address with a valid bit. One request is taken in the last tick of each high half. The fetched byte is captured in the last tick before bus-enable returns and is shown with a one-cycle valid pulse. If the memory is not ready by then, a one-cycle miss pulse is raised instead.

Top module: `vbus_arbiter`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `phi2` and `cpu_be` are high, and `rw_oe`, `vid_addr_oe`, `vid_mem_en`, `vid_valid` and `fetch_miss` are low. `vid_data` is zero. During the first full `phi2` period after reset, `cpu_be` stays high and `req_pop` stays low, even when a request is waiting.
- R2: `phi2` is high for CLK_RATIO/2 fast-clock cycles and then low for CLK_RATIO/2 cycles, repeating. It starts high when reset is released.
- R3: From the second period on, `cpu_be` is low in ticks 0 to HALF-2 of every low half, where tick 0 is the first cycle with `phi2` low and HALF = CLK_RATIO/2. `cpu_be` is high in the last tick of the low half and throughout the high half.
- R4: `rw_oe` is high, meaning the block drives the read/write line to the read level (logic 1), in exactly the cycles where `cpu_be` is low. The block never requests a write.
- R5: `cpu_mem_en` is high only when `phi2` is high and `phi2` delayed by PHI2_DLY fast-clock cycles is also high. With the default settings, this means ticks 2 and 3 of each high half. It is never high at the same time as `vid_mem_en`.
- R6: During a fetch, `vid_addr_oe` is high in ticks 0 to HALF-2 of the low half and drives the popped address on `vid_addr`. `vid_mem_en` is high from tick PHI2_DLY to tick HALF-2.
- R7: `req_pop` follows `req_valid` in the last tick of each high half once the first period has passed, and it is low in every other cycle. This takes at most one request per period. When no request is taken, `vid_addr_oe`, `vid_mem_en`, `vid_valid` and `fetch_miss` stay low for that low half.
- R8: If `mem_ready` is high in tick HALF-2 of a fetch, `mem_rdata` is captured. `vid_data` then shows it, with `vid_valid` high for exactly one cycle in tick HALF-1.
- R9: If `mem_ready` is low in tick HALF-2 of a fetch, `fetch_miss` is high for one cycle in tick HALF-1. In that case `vid_valid` stays low and `vid_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock (CLK_RATIO ticks per phi2 period) |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fetch queue has an address ready |
| req_addr | input | ADDR_W | Address at the head of the fetch queue |
| req_pop | output | 1 | Head of the fetch queue is taken this cycle |
| mem_rdata | input | DATA_W | Read data from the shared memory |
| mem_ready | input | 1 | Memory read data is valid |
| phi2 | output | 1 | CPU phase clock |
| cpu_be | output | 1 | CPU bus-enable; low removes the CPU from the bus |
| rw_oe | output | 1 | When high, the block drives read/write to the read level |
| cpu_mem_en | output | 1 | Gate for CPU-side memory and I/O strobes |
| vid_addr | output | ADDR_W | Video fetch address |
| vid_addr_oe | output | 1 | Output enable for `vid_addr` onto the bus |
| vid_mem_en | output | 1 | Video-side chip and output enable |
| vid_data | output | DATA_W | Last fetched video byte |
| vid_valid | output | 1 | One-cycle pulse: `vid_data` was just updated |
| fetch_miss | output | 1 | One-cycle pulse: the fetch missed its window |

## Verification
All cycle counts below are measured from the first cycle after reset is released. Window m, for m of 1 or more, starts its low half at cycle 8m+4 with the default settings. `req_pop` responds in the same cycle as `req_valid`, at cycle 8m+3. Bus-enable falls and the address is driven one cycle later. `mem_ready` is sampled at cycle 8m+6, and `vid_valid` or `fetch_miss` appears at cycle 8m+7. `cpu_mem_en` rises two cycles after `phi2` rises. The bench counts these cycles step by step. It changes inputs and samples outputs 2 ns after each rising edge, and each check is placed at the cycle predicted above.

// File: rtl/vbus_pkg.sv
package vbus_pkg;

    // Per-tick phase information shared by the arbiter's sub-blocks.
    typedef struct packed {
        logic phi2;      // CPU phase clock
        logic phi2_dly;  // phase clock delayed by the tap register
        logic pop_tick;  // last tick of a high half, fetching armed
        logic vid_slot;  // video owns the bus this tick
        logic cap_tick;  // last tick of video ownership
    } phase_t;

    function automatic int cnt_width(input int half);
        return (half < 2) ? 1 : $clog2(half);
    endfunction

endpackage

// File: rtl/vbus_phase_gen.sv
module vbus_phase_gen
    import vbus_pkg::*;
#(
    parameter int HALF = 4,
    parameter int DLY  = 2
) (
    input  logic   clk,
    input  logic   rst,
    output phase_t ph
);
    localparam int            CW   = cnt_width(HALF);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);
    localparam logic [CW-1:0] CAP  = CW'(HALF - 2);

    logic [CW-1:0]  cnt_q;
    logic           phi2_q;
    logic           armed_q;
    logic [DLY-1:0] tap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            phi2_q  <= 1'b1;
            armed_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            phi2_q <= ~phi2_q;
            if (!phi2_q) armed_q <= 1'b1;  // first full period complete
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    generate
        if (DLY == 1) begin : g_tap_single
            always_ff @(posedge clk) begin
                if (rst) tap_q <= '1;
                else     tap_q <= phi2_q;
            end
        end else begin : g_tap_chain
            always_ff @(posedge clk) begin
                if (rst) tap_q <= '1;
                else     tap_q <= {tap_q[DLY-2:0], phi2_q};
            end
        end
    endgenerate

    always_comb begin
        ph.phi2     = phi2_q;
        ph.phi2_dly = tap_q[DLY-1];
        ph.pop_tick = armed_q & phi2_q & (cnt_q == LAST);
        ph.vid_slot = armed_q & ~phi2_q & (cnt_q <= CAP);
        ph.cap_tick = armed_q & ~phi2_q & (cnt_q == CAP);
    end

    // R3: bus ownership is handed back one tick before phi2 rises
    p_slot_ends_before_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(phi2_q) |-> $past(!ph.vid_slot));

    // R5: the delayed copy never runs ahead of phi2
    p_tap_lags_phi2_r5: assert property (@(posedge clk) disable iff (rst)
        (phi2_q && ph.phi2_dly) |-> $past(phi2_q));

    // R1: once fetching is armed it stays armed until reset
    p_armed_sticky_r1: assert property (@(posedge clk) disable iff (rst)
        armed_q |=> armed_q);

endmodule

// File: rtl/vbus_fetch.sv
module vbus_fetch
    import vbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_t            ph,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              req_pop,
    output logic [ADDR_W-1:0] vid_addr,
    output logic              vid_addr_oe,
    output logic              vid_mem_en,
    output logic [DATA_W-1:0] vid_data,
    output logic              vid_valid,
    output logic              fetch_miss
);
    logic              active_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              valid_q;
    logic              miss_q;

    assign req_pop = ph.pop_tick & req_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            addr_q   <= '0;
            data_q   <= '0;
            valid_q  <= 1'b0;
            miss_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            miss_q  <= 1'b0;
            if (req_pop) begin
                active_q <= 1'b1;
                addr_q   <= req_addr;
            end else if (ph.cap_tick && active_q) begin
                active_q <= 1'b0;
                if (mem_ready) begin
                    data_q  <= mem_rdata;
                    valid_q <= 1'b1;
                end else begin
                    miss_q <= 1'b1;
                end
            end
        end
    end

    assign vid_addr    = addr_q;
    assign vid_addr_oe = ph.vid_slot & active_q;
    assign vid_mem_en  = vid_addr_oe & ~ph.phi2_dly;
    assign vid_data    = data_q;
    assign vid_valid   = valid_q;
    assign fetch_miss  = miss_q;

    // R7: a new request is only taken when the previous fetch has ended
    p_pop_when_idle_r7: assert property (@(posedge clk) disable iff (rst)
        req_pop |-> !active_q);

    // R6: the video strobe waits at least one tick after phi2 falls
    p_strobe_settled_r6: assert property (@(posedge clk) disable iff (rst)
        vid_mem_en |-> (!ph.phi2 && $past(!ph.phi2)));

    // R8: a fetch ends with either data or a miss, never both
    p_result_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({valid_q, miss_q}));

    // R9: results appear the tick after video gives up the bus
    p_result_after_slot_r9: assert property (@(posedge clk) disable iff (rst)
        (valid_q || miss_q) |-> (!ph.vid_slot && $past(ph.vid_slot)));

endmodule

// File: rtl/vbus_arbiter.sv
module vbus_arbiter
    import vbus_pkg::*;
#(
    parameter int CLK_RATIO = 8,
    parameter int PHI2_DLY  = 2,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_pop,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              phi2,
    output logic              cpu_be,
    output logic              rw_oe,
    output logic              cpu_mem_en,
    output logic [ADDR_W-1:0] vid_addr,
    output logic              vid_addr_oe,
    output logic              vid_mem_en,
    output logic [DATA_W-1:0] vid_data,
    output logic              vid_valid,
    output logic              fetch_miss
);
    localparam int HALF = CLK_RATIO / 2;

    phase_t ph;

    vbus_phase_gen #(.HALF(HALF), .DLY(PHI2_DLY)) u_phase (
        .clk (clk),
        .rst (rst),
        .ph  (ph)
    );

    vbus_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fetch (
        .clk         (clk),
        .rst         (rst),
        .ph          (ph),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .mem_rdata   (mem_rdata),
        .mem_ready   (mem_ready),
        .req_pop     (req_pop),
        .vid_addr    (vid_addr),
        .vid_addr_oe (vid_addr_oe),
        .vid_mem_en  (vid_mem_en),
        .vid_data    (vid_data),
        .vid_valid   (vid_valid),
        .fetch_miss  (fetch_miss)
    );

    assign phi2       = ph.phi2;
    assign cpu_be     = ~ph.vid_slot;
    assign rw_oe      = ph.vid_slot;
    assign cpu_mem_en = ph.phi2 & ph.phi2_dly;

    // R3: the CPU is never taken off the bus while phi2 is high
    p_be_in_high_r3: assert property (@(posedge clk) disable iff (rst)
        phi2 |-> cpu_be);

    // R4: video drives the address only with the CPU off and read forced
    p_vid_drive_read_r4: assert property (@(posedge clk) disable iff (rst)
        vid_addr_oe |-> (!cpu_be && rw_oe));

    // R5: the two strobe gates never overlap
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(cpu_mem_en && vid_mem_en));

    // R5: CPU strobes only with the CPU on the bus and phi2 already settled high
    p_cpu_strobe_owned_r5: assert property (@(posedge clk) disable iff (rst)
        cpu_mem_en |-> (cpu_be && $past(phi2)));

endmodule

// File: tb/sim_vbus_arbiter.sv
module sim_vbus_arbiter;
    localparam int RATIO = 8;
    localparam int DLY   = 2;
    localparam int AW    = 16;
    localparam int DW    = 8;

    // {req, addr[15:0], ready, data[7:0]}
    localparam logic [25:0] VECS [6] = '{
        {1'b1, 16'h1234, 1'b1, 8'hA5},
        {1'b1, 16'hFFFF, 1'b1, 8'h3C},
        {1'b1, 16'h0000, 1'b0, 8'hEE},
        {1'b0, 16'hBEEF, 1'b1, 8'h77},
        {1'b1, 16'h8001, 1'b1, 8'h00},
        {1'b1, 16'h7FFE, 1'b0, 8'h11}
    };

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic          req_pop;
    logic [DW-1:0] mem_rdata;
    logic          mem_ready;
    logic          phi2, cpu_be, rw_oe, cpu_mem_en;
    logic [AW-1:0] vid_addr;
    logic          vid_addr_oe, vid_mem_en;
    logic [DW-1:0] vid_data;
    logic          vid_valid, fetch_miss;

    vbus_arbiter #(.CLK_RATIO(RATIO), .PHI2_DLY(DLY), .ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_pop(req_pop), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .phi2(phi2), .cpu_be(cpu_be), .rw_oe(rw_oe), .cpu_mem_en(cpu_mem_en),
        .vid_addr(vid_addr), .vid_addr_oe(vid_addr_oe), .vid_mem_en(vid_mem_en),
        .vid_data(vid_data), .vid_valid(vid_valid), .fetch_miss(fetch_miss)
    );

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic reset_state_checks();
        chk("R1 phi2",        phi2,        1);
        chk("R1 cpu_be",      cpu_be,      1);
        chk("R1 rw_oe",       rw_oe,       0);
        chk("R1 vid_addr_oe", vid_addr_oe, 0);
        chk("R1 vid_mem_en",  vid_mem_en,  0);
        chk("R1 vid_valid",   vid_valid,   0);
        chk("R1 fetch_miss",  fetch_miss,  0);
        chk("R1 vid_data",    vid_data,    0);
    endtask

    initial begin
        logic [DW-1:0] data_exp;
        rst       = 1'b1;
        req_valid = 1'b0;
        req_addr  = '0;
        mem_ready = 1'b0;
        mem_rdata = '0;
        repeat (3) step();
        reset_state_checks();          // R1 while reset held
        rst = 1'b0;                    // now at cycle 0
        reset_state_checks();          // R1 first cycle after release

        // First period: request waiting, nothing may be taken (R1), phi2 shape (R2)
        req_valid = 1'b1;
        req_addr  = 16'hAAAA;
        for (int c = 0; c < RATIO; c++) begin
            chk("R1 no pop first period", req_pop, 0);
            chk("R1 be held first period", cpu_be, 1);
            chk("R2 phi2 first period", phi2, (c < RATIO / 2) ? 1 : 0);
            step();
        end

        // Vector table walk: one phi2 period per entry, starting at cycle 8
        data_exp = '0;
        for (int i = 0; i < 6; i++) begin
            logic          vreq, vrdy, expv, expm;
            logic [AW-1:0] vaddr;
            logic [DW-1:0] vdata;
            vreq  = VECS[i][25];
            vaddr = VECS[i][24:9];
            vrdy  = VECS[i][8];
            vdata = VECS[i][7:0];
            // tick 0 of high half
            chk("R2 phi2 high", phi2, 1);
            chk("R5 cpu_mem_en tick0", cpu_mem_en, 0);
            step();
            // tick 1
            chk("R5 cpu_mem_en tick1", cpu_mem_en, 0);
            chk("R7 no pop mid high", req_pop, 0);
            step();
            // tick 2
            chk("R5 cpu_mem_en tick2", cpu_mem_en, 1);
            req_valid = vreq;
            req_addr  = vaddr;
            step();
            // tick 3: last tick of high half
            chk("R7 pop", req_pop, vreq);
            chk("R3 be high end of high half", cpu_be, 1);
            chk("R5 cpu_mem_en tick3", cpu_mem_en, 1);
            step();
            // low tick 0
            chk("R2 phi2 low", phi2, 0);
            chk("R3 be low tick0", cpu_be, 0);
            chk("R4 rw_oe tick0", rw_oe, 1);
            chk("R6 addr_oe tick0", vid_addr_oe, vreq);
            if (vreq) chk("R6 vid_addr", vid_addr, vaddr);
            chk("R7 no pop in low half", req_pop, 0);
            chk("R5 cpu_mem_en low", cpu_mem_en, 0);
            step();
            // low tick 1
            chk("R6 strobe held off tick1", vid_mem_en, 0);
            mem_ready = vrdy;
            mem_rdata = vdata;
            step();
            // low tick 2: capture tick
            chk("R6 strobe tick2", vid_mem_en, vreq);
            chk("R3 be low tick2", cpu_be, 0);
            chk("R4 rw_oe tick2", rw_oe, 1);
            step();
            // low tick 3
            mem_ready = 1'b0;
            mem_rdata = 8'h5A;
            expv = vreq & vrdy;
            expm = vreq & ~vrdy;
            if (expv) data_exp = vdata;
            chk("R3 be back tick3", cpu_be, 1);
            chk("R4 rw_oe released tick3", rw_oe, 0);
            chk("R6 addr_oe released tick3", vid_addr_oe, 0);
            chk("R8 vid_valid", vid_valid, expv);
            chk("R9 fetch_miss", fetch_miss, expm);
            chk("R8 R9 vid_data", vid_data, data_exp);
            step();
        end
        chk("R8 valid is one cycle", vid_valid, 0);
        chk("R9 miss is one cycle", fetch_miss, 0);

        // Directed: reset in mid-run returns to the reset state (R1)
        req_valid = 1'b1;
        req_addr  = 16'h5555;
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
        reset_state_checks();
        for (int c = 0; c < RATIO; c++) begin
            chk("R1 be held after reset", cpu_be, 1);
            chk("R1 addr_oe off after reset", vid_addr_oe, 0);
            chk("R1 no pop after reset", req_pop, 0);
            step();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule